// File: doc/BRIEF.md
# Subset Instruction Operand Decoder

This block takes one raw 32-bit instruction word from a fixed-width load/store RISC instruction set and turns it into the fields an issue stage needs. It reports the operation class, which register indices are read on three read ports, the register index that is written, a fully extended 32-bit immediate, and the per-instruction flags: record, link, absolute address and base update. It also gives the memory access size, the branch condition fields, the special register a branch jumps through, the compare target field and the rotate shift and mask fields.

The decoder is purely combinational, so its outputs follow the inputs within the same cycle. An endianness input says how the four instruction bytes arrived. In little-endian mode the bytes are reversed before any field is looked at. The decoder recognises only a defined subset of the instruction set: register/register and register/immediate arithmetic and logic, indexed and displacement loads and stores of words, halfwords and bytes, compare, the three rotate-with-mask forms, and the relative, conditional and register-indirect branches. Any other word raises the illegal output and leaves every other output at zero.

Top module: `opdec_top`

Bit positions below are numbered 31 (most significant) down to 0, and refer to the word after byte ordering. The primary opcode is bits 31:26. The extended opcode is bits 10:1. Field A is bits 25:21, field B is bits 20:16, field C is bits 15:11 and the 16-bit immediate is bits 15:0. `op_class` encoding: 0 none, 1 add, 2 and, 3 or, 4 load, 5 store, 6 compare, 7 rotate, 8 branch.

## Requirements
- R1: With `big_endian`=1 the word is decoded as given. With `big_endian`=0 byte 0 and byte 3 swap places, as do byte 1 and byte 2, and the result is decoded.
- R2: A word outside the subset drives `illegal`=1 and every other output to 0, including `op_class`. A word inside the subset drives `illegal`=0 and a nonzero `op_class`.
- R3: Primary opcode 31 recognises six extended opcodes. 266 is add: write A, read1 B, read2 C, record from bit 0. 28 is and and 444 is or: write B, read3 A, read2 C, record from bit 0. 23 is an indexed word load: write A, read1 B, read2 C, size 4. 151 is an indexed word store: read3 A, read1 B, read2 C, size 4. 0 is compare. Any other extended opcode, 778 among them, is illegal.
- R4: The immediate arithmetic and logic forms use these extender modes. Opcode 14 uses signed low: the 16-bit field sign-extended. 15 uses signed high: the field shifted left 16 and then sign-extended from bit 31. 24 uses unsigned low: the field zero-extended. 25 uses unsigned high: the field shifted left 16. 28 uses unsigned low and 29 uses unsigned high, and both of these force record=1. 14 and 15 are class add, 24 and 25 class or, 28 and 29 class and.
- R5: Opcodes 14 and 15 route write A and read1 B. Opcodes 24, 25, 28 and 29 route write B and read3 A. None of the six uses read2.
- R6: The displacement loads 32, 33, 34 and 40 route write A and read1 B. The displacement stores 36, 37, 38 and 44 route read3 A and read1 B and have no write. All eight use a signed-low immediate.
- R7: The access size is 4 for opcodes 32, 33, 36 and 37. It is 2 for 40 and 44 and 1 for 34 and 38. The update flag is 1 only for 33 and 37.
- R8: The record flag equals bit 0 for add, and, or and the rotates. It is forced to 1 for opcodes 28 and 29 and is 0 for everything else.
- R9: Compare routes read1 B and read2 C. It outputs bits 25:23 as `crf_sel` and has no write.
- R10: The rotates 20, 21 and 23 route write B and read3 A, with mask begin bits 10:6 and mask end bits 5:1. Opcodes 20 and 21 put bits 15:11 on `shamt`. Opcode 23 instead routes read2 C and leaves `shamt` at 0.
- R11: Opcode 18 is a branch. Its immediate is bits 25:2 sign-extended and multiplied by 4. Link is bit 0 and absolute is bit 1.
- R12: Opcode 16 is a branch. Its immediate is bits 15:2 sign-extended and multiplied by 4. `bo_field` is A and `bi_field` is B. Link is bit 0 and absolute is bit 1.
- R13: Opcode 19 with extended opcode 16 selects `spr_sel`=1 (link register), and with extended opcode 528 selects `spr_sel`=2 (count register). Both pass A and B to `bo_field` and `bi_field`, take link from bit 0 and have a zero immediate. Any other extended opcode under 19 is illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn_raw | input | 32 | Instruction word as fetched |
| big_endian | input | 1 | 1: bytes in big-endian order, 0: reverse before decoding |
| illegal | output | 1 | Word is outside the subset |
| op_class | output | 4 | Operation class code |
| rd1_en | output | 1 | Read port 1 used |
| rd1_sel | output | 5 | Read port 1 register index |
| rd2_en | output | 1 | Read port 2 used |
| rd2_sel | output | 5 | Read port 2 register index |
| rd3_en | output | 1 | Read port 3 used |
| rd3_sel | output | 5 | Read port 3 register index |
| wr_en | output | 1 | Register write used |
| wr_sel | output | 5 | Write register index |
| imm_val | output | 32 | Extended immediate or branch displacement |
| rec_flag | output | 1 | Record result into condition field |
| link_flag | output | 1 | Branch saves return address |
| abs_flag | output | 1 | Branch target is absolute |
| upd_flag | output | 1 | Load/store writes back its base |
| mem_size | output | 4 | Access size in bytes, 0 if none |
| bo_field | output | 5 | Branch condition options |
| bi_field | output | 5 | Branch condition bit index |
| spr_sel | output | 2 | Branch target register: 0 none, 1 link, 2 count |
| crf_sel | output | 3 | Compare target field |
| shamt | output | 5 | Immediate rotate amount |
| mask_begin | output | 5 | Rotate mask start |
| mask_end | output | 5 | Rotate mask end |

## Verification
Directed words cover each opcode and extended opcode of the subset. They use immediates with the top bit set and clear, so that the four extender modes give different results, and displacements with the sign bit set, so that a zero-extension or a missing shift shows up. Each word is presented twice, once in each byte order. Raw words are also fed in the wrong order, which turns legal instructions into other or illegal ones and separates a missing byte swap from a doubled one. Seeded random words with a forced legal opcode check the field routing with arbitrary register indices. These separate the two register-field positions that are easily confused, such as the destination being field A for add and field B for or and rotate. Fully random words, together with near-miss extended opcodes, check that everything outside the subset is rejected and leaves every output silent.

// File: rtl/opdec_pkg.sv
package opdec_pkg;

    localparam int INSN_W  = 32;
    localparam int BYTE_W  = 8;
    localparam int NBYTES  = INSN_W / BYTE_W;
    localparam int RIDX_W  = 5;
    localparam int HALF_W  = 16;
    localparam int OPC_W   = 6;
    localparam int XO_W    = 10;
    localparam int SIZE_W  = 4;
    localparam int CRF_W   = 3;
    localparam int SPR_W   = 2;
    localparam int CLS_W   = 4;
    localparam int LI_W    = 24;
    localparam int BD_W    = 14;

    localparam int OPC_LSB = INSN_W - OPC_W;
    localparam int FA_LSB  = OPC_LSB - RIDX_W;
    localparam int FB_LSB  = FA_LSB - RIDX_W;
    localparam int FC_LSB  = FB_LSB - RIDX_W;
    localparam int MB_LSB  = FC_LSB - RIDX_W;
    localparam int ME_LSB  = MB_LSB - RIDX_W;

    typedef enum logic [CLS_W-1:0] {
        CLS_NONE   = 4'd0,
        CLS_ADD    = 4'd1,
        CLS_AND    = 4'd2,
        CLS_OR     = 4'd3,
        CLS_LOAD   = 4'd4,
        CLS_STORE  = 4'd5,
        CLS_CMP    = 4'd6,
        CLS_ROT    = 4'd7,
        CLS_BRANCH = 4'd8
    } op_class_e;

    typedef enum logic [2:0] {
        IMM_NONE,
        IMM_ULO,
        IMM_UHI,
        IMM_SLO,
        IMM_SHI,
        IMM_LI,
        IMM_BD
    } imm_mode_e;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_FA,
        SRC_FB,
        SRC_FC
    } reg_src_e;

    typedef enum logic [SPR_W-1:0] {
        SPR_NONE  = 2'd0,
        SPR_LINK  = 2'd1,
        SPR_COUNT = 2'd2
    } spr_e;

    typedef struct packed {
        logic              illegal;
        op_class_e         cls;
        reg_src_e          rd1;
        reg_src_e          rd2;
        reg_src_e          rd3;
        reg_src_e          wr;
        imm_mode_e         imm;
        logic              rec_force;
        logic              rec_bit0;
        logic              lk_bit0;
        logic              aa_bit1;
        logic              upd;
        logic [SIZE_W-1:0] size;
        logic              bobi;
        spr_e              spr;
        logic              crf;
        logic              sh;
        logic              mbme;
    } ctl_t;

    function automatic logic [RIDX_W-1:0] pick_reg(reg_src_e s, logic [INSN_W-1:0] w);
        case (s)
            SRC_FA:  return w[FA_LSB +: RIDX_W];
            SRC_FB:  return w[FB_LSB +: RIDX_W];
            SRC_FC:  return w[FC_LSB +: RIDX_W];
            default: return '0;
        endcase
    endfunction

    function automatic logic [INSN_W-1:0] extend_half(imm_mode_e m, logic [HALF_W-1:0] f);
        logic [INSN_W-1:0] hi;
        hi = {f, {(INSN_W-HALF_W){1'b0}}};
        case (m)
            IMM_ULO: return {{(INSN_W-HALF_W){1'b0}}, f};
            IMM_UHI: return hi;
            IMM_SLO: return {{(INSN_W-HALF_W){f[HALF_W-1]}}, f};
            IMM_SHI: return {{(INSN_W-INSN_W){1'b0}}, hi[INSN_W-1], hi[INSN_W-2:0]};
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/opdec_byteorder.sv
module opdec_byteorder
    import opdec_pkg::*;
(
    input  logic [INSN_W-1:0] raw,
    input  logic              big_endian,
    output logic [INSN_W-1:0] word
);
    logic [INSN_W-1:0] reversed;

    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        assign reversed[b*BYTE_W +: BYTE_W] = raw[(NBYTES-1-b)*BYTE_W +: BYTE_W];
    end

    assign word = big_endian ? raw : reversed;
endmodule

// File: rtl/opdec_classify.sv
module opdec_classify
    import opdec_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    input  logic [XO_W-1:0]  xop,
    output ctl_t             ctl
);
    always_comb begin
        ctl = '0;
        case (opcode)
            6'd31: begin
                case (xop)
                    10'd266: begin
                        ctl.cls = CLS_ADD; ctl.wr = SRC_FA; ctl.rd1 = SRC_FB;
                        ctl.rd2 = SRC_FC; ctl.rec_bit0 = 1'b1;
                    end
                    10'd28, 10'd444: begin
                        ctl.cls = (xop == 10'd28) ? CLS_AND : CLS_OR;
                        ctl.wr = SRC_FB; ctl.rd3 = SRC_FA; ctl.rd2 = SRC_FC;
                        ctl.rec_bit0 = 1'b1;
                    end
                    10'd23: begin
                        ctl.cls = CLS_LOAD; ctl.wr = SRC_FA; ctl.rd1 = SRC_FB;
                        ctl.rd2 = SRC_FC; ctl.size = 4'd4;
                    end
                    10'd151: begin
                        ctl.cls = CLS_STORE; ctl.rd3 = SRC_FA; ctl.rd1 = SRC_FB;
                        ctl.rd2 = SRC_FC; ctl.size = 4'd4;
                    end
                    10'd0: begin
                        ctl.cls = CLS_CMP; ctl.rd1 = SRC_FB; ctl.rd2 = SRC_FC;
                        ctl.crf = 1'b1;
                    end
                    default: ctl.illegal = 1'b1;
                endcase
            end
            6'd14, 6'd15: begin
                ctl.cls = CLS_ADD; ctl.wr = SRC_FA; ctl.rd1 = SRC_FB;
                ctl.imm = (opcode == 6'd14) ? IMM_SLO : IMM_SHI;
            end
            6'd24, 6'd25, 6'd28, 6'd29: begin
                ctl.cls = (opcode[2]) ? CLS_AND : CLS_OR;
                ctl.wr = SRC_FB; ctl.rd3 = SRC_FA;
                ctl.imm = (opcode[0]) ? IMM_UHI : IMM_ULO;
                ctl.rec_force = opcode[2];
            end
            6'd32, 6'd33, 6'd34, 6'd40: begin
                ctl.cls = CLS_LOAD; ctl.wr = SRC_FA; ctl.rd1 = SRC_FB;
                ctl.imm = IMM_SLO; ctl.upd = (opcode == 6'd33);
                ctl.size = (opcode == 6'd34) ? 4'd1 : (opcode == 6'd40) ? 4'd2 : 4'd4;
            end
            6'd36, 6'd37, 6'd38, 6'd44: begin
                ctl.cls = CLS_STORE; ctl.rd3 = SRC_FA; ctl.rd1 = SRC_FB;
                ctl.imm = IMM_SLO; ctl.upd = (opcode == 6'd37);
                ctl.size = (opcode == 6'd38) ? 4'd1 : (opcode == 6'd44) ? 4'd2 : 4'd4;
            end
            6'd20, 6'd21, 6'd23: begin
                ctl.cls = CLS_ROT; ctl.wr = SRC_FB; ctl.rd3 = SRC_FA;
                ctl.rec_bit0 = 1'b1; ctl.mbme = 1'b1;
                if (opcode == 6'd23) ctl.rd2 = SRC_FC;
                else                 ctl.sh  = 1'b1;
            end
            6'd18: begin
                ctl.cls = CLS_BRANCH; ctl.imm = IMM_LI;
                ctl.lk_bit0 = 1'b1; ctl.aa_bit1 = 1'b1;
            end
            6'd16: begin
                ctl.cls = CLS_BRANCH; ctl.imm = IMM_BD; ctl.bobi = 1'b1;
                ctl.lk_bit0 = 1'b1; ctl.aa_bit1 = 1'b1;
            end
            6'd19: begin
                if (xop == 10'd16 || xop == 10'd528) begin
                    ctl.cls = CLS_BRANCH; ctl.bobi = 1'b1; ctl.lk_bit0 = 1'b1;
                    ctl.spr = (xop == 10'd16) ? SPR_LINK : SPR_COUNT;
                end else begin
                    ctl.illegal = 1'b1;
                end
            end
            default: ctl.illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/opdec_immext.sv
module opdec_immext
    import opdec_pkg::*;
(
    input  logic [OPC_LSB-1:0] body,
    input  imm_mode_e          mode,
    output logic [INSN_W-1:0]  imm
);
    localparam int LI_PAD = INSN_W - LI_W - 2;
    localparam int BD_PAD = INSN_W - BD_W - 2;

    logic [LI_W-1:0] li;
    logic [BD_W-1:0] bd;

    assign li = body[LI_W+1:2];
    assign bd = body[BD_W+1:2];

    always_comb begin
        case (mode)
            IMM_LI:  imm = {{LI_PAD{li[LI_W-1]}}, li, 2'b00};
            IMM_BD:  imm = {{BD_PAD{bd[BD_W-1]}}, bd, 2'b00};
            default: imm = extend_half(mode, body[HALF_W-1:0]);
        endcase
    end
endmodule

// File: rtl/opdec_top.sv
module opdec_top
    import opdec_pkg::*;
(
    input  logic [31:0] insn_raw,
    input  logic        big_endian,
    output logic        illegal,
    output logic [3:0]  op_class,
    output logic        rd1_en,
    output logic [4:0]  rd1_sel,
    output logic        rd2_en,
    output logic [4:0]  rd2_sel,
    output logic        rd3_en,
    output logic [4:0]  rd3_sel,
    output logic        wr_en,
    output logic [4:0]  wr_sel,
    output logic [31:0] imm_val,
    output logic        rec_flag,
    output logic        link_flag,
    output logic        abs_flag,
    output logic        upd_flag,
    output logic [3:0]  mem_size,
    output logic [4:0]  bo_field,
    output logic [4:0]  bi_field,
    output logic [1:0]  spr_sel,
    output logic [2:0]  crf_sel,
    output logic [4:0]  shamt,
    output logic [4:0]  mask_begin,
    output logic [4:0]  mask_end
);
    logic [INSN_W-1:0] w;
    ctl_t              ctl;

    opdec_byteorder u_order (
        .raw        (insn_raw),
        .big_endian (big_endian),
        .word       (w)
    );

    opdec_classify u_class (
        .opcode (w[OPC_LSB +: OPC_W]),
        .xop    (w[XO_W:1]),
        .ctl    (ctl)
    );

    opdec_immext u_imm (
        .body (w[OPC_LSB-1:0]),
        .mode (ctl.imm),
        .imm  (imm_val)
    );

    assign illegal  = ctl.illegal;
    assign op_class = ctl.cls;

    assign rd1_en  = (ctl.rd1 != SRC_NONE);
    assign rd2_en  = (ctl.rd2 != SRC_NONE);
    assign rd3_en  = (ctl.rd3 != SRC_NONE);
    assign wr_en   = (ctl.wr  != SRC_NONE);
    assign rd1_sel = pick_reg(ctl.rd1, w);
    assign rd2_sel = pick_reg(ctl.rd2, w);
    assign rd3_sel = pick_reg(ctl.rd3, w);
    assign wr_sel  = pick_reg(ctl.wr,  w);

    assign rec_flag  = ctl.rec_force | (ctl.rec_bit0 & w[0]);
    assign link_flag = ctl.lk_bit0 & w[0];
    assign abs_flag  = ctl.aa_bit1 & w[1];
    assign upd_flag  = ctl.upd;
    assign mem_size  = ctl.size;
    assign spr_sel   = ctl.spr;

    assign bo_field   = ctl.bobi ? w[FA_LSB +: RIDX_W] : '0;
    assign bi_field   = ctl.bobi ? w[FB_LSB +: RIDX_W] : '0;
    assign crf_sel    = ctl.crf  ? w[INSN_W-OPC_W-1 -: CRF_W] : '0;
    assign shamt      = ctl.sh   ? w[FC_LSB +: RIDX_W] : '0;
    assign mask_begin = ctl.mbme ? w[MB_LSB +: RIDX_W] : '0;
    assign mask_end   = ctl.mbme ? w[ME_LSB +: RIDX_W] : '0;
endmodule

// File: rtl/opdec_checker.sv
module opdec_checker
    import opdec_pkg::*;
(
    input logic [31:0] insn_raw,
    input logic        big_endian,
    input logic        illegal,
    input logic [3:0]  op_class,
    input logic        rd1_en,
    input logic [4:0]  rd1_sel,
    input logic        rd2_en,
    input logic [4:0]  rd2_sel,
    input logic        rd3_en,
    input logic [4:0]  rd3_sel,
    input logic        wr_en,
    input logic [4:0]  wr_sel,
    input logic [31:0] imm_val,
    input logic        rec_flag,
    input logic        link_flag,
    input logic        abs_flag,
    input logic        upd_flag,
    input logic [3:0]  mem_size,
    input logic [4:0]  bo_field,
    input logic [4:0]  bi_field,
    input logic [1:0]  spr_sel,
    input logic [2:0]  crf_sel,
    input logic [4:0]  shamt,
    input logic [4:0]  mask_begin,
    input logic [4:0]  mask_end
);
    logic memop;
    logic any_out;

    assign memop = (op_class == CLS_LOAD) || (op_class == CLS_STORE);
    assign any_out = (|op_class) | rd1_en | (|rd1_sel) | rd2_en | (|rd2_sel)
                   | rd3_en | (|rd3_sel) | wr_en | (|wr_sel) | (|imm_val)
                   | rec_flag | link_flag | abs_flag | upd_flag | (|mem_size)
                   | (|bo_field) | (|bi_field) | (|spr_sel) | (|crf_sel)
                   | (|shamt) | (|mask_begin) | (|mask_end);

    always_comb begin
        if (!$isunknown({insn_raw, big_endian})) begin
            if (illegal) begin
                assert_illegal_silent_R2: assert (!any_out);
            end else begin
                assert_legal_has_class_R2: assert (op_class != CLS_NONE);
            end
            if (upd_flag) begin
                assert_update_memop_R7: assert (memop);
            end
            assert_size_onehot_R7: assert ($onehot0(mem_size) && ((mem_size != 4'd0) == memop));
            if (op_class == CLS_STORE) begin
                assert_store_no_write_R6: assert (!wr_en && rd1_en && rd3_en);
            end
            if (spr_sel != SPR_NONE) begin
                assert_spr_branch_R13: assert (op_class == CLS_BRANCH && imm_val == 32'd0);
            end
            if (op_class != CLS_CMP) begin
                assert_crf_only_cmp_R9: assert (crf_sel == 3'd0);
            end
            if (op_class != CLS_BRANCH) begin
                assert_branch_flags_R11: assert (!link_flag && !abs_flag && bo_field == 5'd0 && bi_field == 5'd0);
            end
        end
    end
endmodule

bind opdec_top opdec_checker u_chk (.*);

// File: tb/opdec_top_test.sv
module opdec_top_test;

    typedef struct packed {
        logic        illegal;
        logic [3:0]  cls;
        logic        r1e; logic [4:0] r1;
        logic        r2e; logic [4:0] r2;
        logic        r3e; logic [4:0] r3;
        logic        we;  logic [4:0] wr;
        logic [31:0] imm;
        logic        rec, lnk, aa, upd;
        logic [3:0]  size;
        logic [4:0]  bo, bi;
        logic [1:0]  spr;
        logic [2:0]  crf;
        logic [4:0]  sh, mb, me;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [31:0] insn_raw = 32'd0;
    logic big_endian = 1'b1;

    logic illegal, rd1_en, rd2_en, rd3_en, wr_en;
    logic rec_flag, link_flag, abs_flag, upd_flag;
    logic [3:0] op_class, mem_size;
    logic [4:0] rd1_sel, rd2_sel, rd3_sel, wr_sel, bo_field, bi_field;
    logic [4:0] shamt, mask_begin, mask_end;
    logic [31:0] imm_val;
    logic [1:0] spr_sel;
    logic [2:0] crf_sel;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    opdec_top uut (.*);

    function automatic logic [31:0] bswap(input logic [31:0] x);
        return {x[7:0], x[15:8], x[23:16], x[31:24]};
    endfunction

    function automatic exp_t ref_model(input logic [31:0] w);
        exp_t e;
        logic [5:0] po;
        logic [9:0] xo;
        logic [4:0] fa, fb, fc;
        logic [15:0] d;
        e = '0;
        po = w[31:26]; xo = w[10:1];
        fa = w[25:21]; fb = w[20:16]; fc = w[15:11]; d = w[15:0];
        case (po)
            6'd31: case (xo)
                10'd266: begin e.cls = 1; e.we = 1; e.wr = fa; e.r1e = 1; e.r1 = fb;
                               e.r2e = 1; e.r2 = fc; e.rec = w[0]; end
                10'd28, 10'd444: begin e.cls = (xo == 10'd28) ? 4'd2 : 4'd3;
                               e.we = 1; e.wr = fb; e.r3e = 1; e.r3 = fa;
                               e.r2e = 1; e.r2 = fc; e.rec = w[0]; end
                10'd23: begin e.cls = 4; e.we = 1; e.wr = fa; e.r1e = 1; e.r1 = fb;
                               e.r2e = 1; e.r2 = fc; e.size = 4; end
                10'd151: begin e.cls = 5; e.r3e = 1; e.r3 = fa; e.r1e = 1; e.r1 = fb;
                               e.r2e = 1; e.r2 = fc; e.size = 4; end
                10'd0: begin e.cls = 6; e.r1e = 1; e.r1 = fb; e.r2e = 1; e.r2 = fc;
                               e.crf = w[25:23]; end
                default: e.illegal = 1;
            endcase
            6'd14: begin e.cls = 1; e.we = 1; e.wr = fa; e.r1e = 1; e.r1 = fb;
                         e.imm = {{16{d[15]}}, d}; end
            6'd15: begin e.cls = 1; e.we = 1; e.wr = fa; e.r1e = 1; e.r1 = fb;
                         e.imm = {d, 16'h0}; end
            6'd24, 6'd28: begin e.cls = (po == 6'd28) ? 4'd2 : 4'd3; e.we = 1; e.wr = fb;
                         e.r3e = 1; e.r3 = fa; e.imm = {16'h0, d}; e.rec = (po == 6'd28); end
            6'd25, 6'd29: begin e.cls = (po == 6'd29) ? 4'd2 : 4'd3; e.we = 1; e.wr = fb;
                         e.r3e = 1; e.r3 = fa; e.imm = {d, 16'h0}; e.rec = (po == 6'd29); end
            6'd32, 6'd33, 6'd34, 6'd40: begin e.cls = 4; e.we = 1; e.wr = fa;
                         e.r1e = 1; e.r1 = fb; e.imm = {{16{d[15]}}, d};
                         e.upd = (po == 6'd33);
                         e.size = (po == 6'd34) ? 4'd1 : (po == 6'd40) ? 4'd2 : 4'd4; end
            6'd36, 6'd37, 6'd38, 6'd44: begin e.cls = 5; e.r3e = 1; e.r3 = fa;
                         e.r1e = 1; e.r1 = fb; e.imm = {{16{d[15]}}, d};
                         e.upd = (po == 6'd37);
                         e.size = (po == 6'd38) ? 4'd1 : (po == 6'd44) ? 4'd2 : 4'd4; end
            6'd20, 6'd21, 6'd23: begin e.cls = 7; e.we = 1; e.wr = fb; e.r3e = 1; e.r3 = fa;
                         e.mb = w[10:6]; e.me = w[5:1]; e.rec = w[0];
                         if (po == 6'd23) begin e.r2e = 1; e.r2 = fc; end
                         else e.sh = fc; end
            6'd18: begin e.cls = 8; e.imm = {{6{w[25]}}, w[25:2], 2'b00};
                         e.lnk = w[0]; e.aa = w[1]; end
            6'd16: begin e.cls = 8; e.imm = {{16{w[15]}}, w[15:2], 2'b00};
                         e.bo = fa; e.bi = fb; e.lnk = w[0]; e.aa = w[1]; end
            6'd19: begin
                if (xo == 10'd16 || xo == 10'd528) begin
                    e.cls = 8; e.bo = fa; e.bi = fb; e.lnk = w[0];
                    e.spr = (xo == 10'd16) ? 2'd1 : 2'd2;
                end else e.illegal = 1;
            end
            default: e.illegal = 1;
        endcase
        return e;
    endfunction

    function automatic string req_of(input logic [31:0] w);
        case (w[31:26])
            6'd31: return "R3";
            6'd14, 6'd15, 6'd24, 6'd25, 6'd28, 6'd29: return "R4";
            6'd32, 6'd33, 6'd34, 6'd40, 6'd36, 6'd37, 6'd38, 6'd44: return "R6";
            6'd20, 6'd21, 6'd23: return "R10";
            6'd18: return "R11";
            6'd16: return "R12";
            6'd19: return "R13";
            default: return "R2";
        endcase
    endfunction

    task automatic check_raw(input logic [31:0] raw, input logic be, input string tag);
        exp_t got, exp;
        @(negedge clk);
        insn_raw = raw;
        big_endian = be;
        @(posedge clk);
        #1;
        exp = ref_model(be ? raw : bswap(raw));
        got.illegal = illegal; got.cls = op_class;
        got.r1e = rd1_en; got.r1 = rd1_sel; got.r2e = rd2_en; got.r2 = rd2_sel;
        got.r3e = rd3_en; got.r3 = rd3_sel; got.we = wr_en; got.wr = wr_sel;
        got.imm = imm_val; got.rec = rec_flag; got.lnk = link_flag; got.aa = abs_flag;
        got.upd = upd_flag; got.size = mem_size; got.bo = bo_field; got.bi = bi_field;
        got.spr = spr_sel; got.crf = crf_sel; got.sh = shamt; got.mb = mask_begin;
        got.me = mask_end;
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s word=%h be=%0d actual=%h expected=%h", tag, raw, be, got, exp);
        end
    endtask

    // R1: every instruction is checked in both byte orders
    task automatic check_word(input logic [31:0] w, input string tag);
        check_raw(w, 1'b1, tag);
        check_raw(bswap(w), 1'b0, tag);
    endtask

    function automatic logic [31:0] enc_x(input logic [9:0] xo, input logic [4:0] a, b, c, input logic rc);
        return {6'd31, a, b, c, xo, rc};
    endfunction
    function automatic logic [31:0] enc_d(input logic [5:0] po, input logic [4:0] a, b, input logic [15:0] d);
        return {po, a, b, d};
    endfunction
    function automatic logic [31:0] enc_m(input logic [5:0] po, input logic [4:0] s, a, c, mb, me, input logic rc);
        return {po, s, a, c, mb, me, rc};
    endfunction

    initial begin
        logic [31:0] w;
        logic [5:0] legal_po [22] = '{6'd31, 6'd14, 6'd15, 6'd24, 6'd25, 6'd28, 6'd29,
            6'd32, 6'd33, 6'd34, 6'd40, 6'd36, 6'd37, 6'd38, 6'd44, 6'd20, 6'd21, 6'd23,
            6'd18, 6'd16, 6'd19, 6'd31};
        logic [9:0] x31 [6] = '{10'd266, 10'd28, 10'd444, 10'd23, 10'd151, 10'd0};
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // R2: all-zero word after reset is outside the subset
        check_word(32'h0000_0000, "R2 zero word");
        // R1: byte order differs, raw words fed in the wrong order
        check_raw(enc_d(6'd14, 5'd3, 5'd4, 16'h1234), 1'b0, "R1 wrong order");
        check_raw(enc_x(10'd266, 5'd1, 5'd2, 5'd3, 1'b0), 1'b0, "R1 wrong order x");
        check_raw(32'h3864_1234, 1'b1, "R1 direct");

        // R3 register-register forms; R8 record bit
        check_word(enc_x(10'd266, 5'd5, 5'd6, 5'd7, 1'b0), "R3 add");
        check_word(enc_x(10'd266, 5'd31, 5'd0, 5'd17, 1'b1), "R8 add dot");
        check_word(enc_x(10'd28, 5'd9, 5'd10, 5'd11, 1'b1), "R3 and dot");
        check_word(enc_x(10'd444, 5'd12, 5'd13, 5'd14, 1'b0), "R3 or");
        check_word(enc_x(10'd23, 5'd1, 5'd2, 5'd3, 1'b1), "R3 indexed load");
        check_word(enc_x(10'd151, 5'd4, 5'd5, 5'd6, 1'b0), "R3 indexed store");
        check_word(enc_x(10'd778, 5'd1, 5'd2, 5'd3, 1'b0), "R3 overflow add illegal");
        check_word(enc_x(10'd267, 5'd1, 5'd2, 5'd3, 1'b0), "R2 near miss xo");
        // R9 compare
        check_word(enc_x(10'd0, 5'b11100, 5'd21, 5'd22, 1'b0), "R9 compare bf7");

        // R4/R5 immediate forms with both sign cases
        check_word(enc_d(6'd14, 5'd3, 5'd4, 16'h8000), "R4 signed low neg");
        check_word(enc_d(6'd14, 5'd3, 5'd4, 16'h7fff), "R5 signed low pos");
        check_word(enc_d(6'd15, 5'd8, 5'd9, 16'hffff), "R4 signed high");
        check_word(enc_d(6'd24, 5'd10, 5'd11, 16'hffff), "R4 unsigned low");
        check_word(enc_d(6'd25, 5'd10, 5'd11, 16'h8001), "R4 unsigned high");
        check_word(enc_d(6'd28, 5'd1, 5'd2, 16'h00f0), "R8 andi forced record");
        check_word(enc_d(6'd29, 5'd1, 5'd2, 16'hf000), "R8 andis forced record");

        // R6/R7 loads and stores
        check_word(enc_d(6'd32, 5'd1, 5'd2, 16'h8004), "R6 word load");
        check_word(enc_d(6'd33, 5'd1, 5'd2, 16'h0010), "R7 word load update");
        check_word(enc_d(6'd34, 5'd3, 5'd4, 16'hfffe), "R7 byte load");
        check_word(enc_d(6'd40, 5'd5, 5'd6, 16'h0002), "R7 half load");
        check_word(enc_d(6'd36, 5'd7, 5'd8, 16'h0100), "R6 word store");
        check_word(enc_d(6'd37, 5'd9, 5'd10, 16'hff00), "R7 word store update");
        check_word(enc_d(6'd38, 5'd11, 5'd12, 16'h0001), "R7 byte store");
        check_word(enc_d(6'd44, 5'd13, 5'd14, 16'h7ffe), "R7 half store");
        check_word(enc_d(6'd41, 5'd1, 5'd2, 16'h0000), "R2 unlisted update load");

        // R10 rotates
        check_word(enc_m(6'd21, 5'd1, 5'd2, 5'd31, 5'd0, 5'd31, 1'b1), "R10 rotate imm dot");
        check_word(enc_m(6'd20, 5'd3, 5'd4, 5'd5, 5'd6, 5'd7, 1'b0), "R10 rotate insert");
        check_word(enc_m(6'd23, 5'd8, 5'd9, 5'd10, 5'd11, 5'd12, 1'b1), "R10 rotate reg");

        // R11 unconditional branches
        check_word({6'd18, 24'h80_0000, 1'b0, 1'b0}, "R11 branch neg");
        check_word({6'd18, 24'h12_3456, 1'b1, 1'b1}, "R11 branch abs link");
        // R12 conditional branches
        check_word({6'd16, 5'd20, 5'd3, 14'h2000, 1'b0, 1'b1}, "R12 cond neg link");
        check_word({6'd16, 5'd12, 5'd31, 14'h0abc, 1'b1, 1'b0}, "R12 cond abs");
        // R13 branch through register
        check_word({6'd19, 5'd20, 5'd2, 3'b0, 2'd3, 10'd16, 1'b0}, "R13 to link");
        check_word({6'd19, 5'd12, 5'd7, 3'b0, 2'd1, 10'd528, 1'b1}, "R13 to count link");
        check_word({6'd19, 5'd12, 5'd7, 5'd0, 10'd150, 1'b0}, "R13 other xo illegal");

        // random legal-opcode words
        for (int i = 0; i < 600; i++) begin
            w = $urandom;
            w[31:26] = legal_po[$urandom_range(0, 21)];
            if (w[31:26] == 6'd31) w[10:1] = x31[$urandom_range(0, 5)];
            if (w[31:26] == 6'd19) w[10:1] = ($urandom_range(0, 1) == 0) ? 10'd16 : 10'd528;
            check_word(w, req_of(w));
        end
        // fully random words
        for (int i = 0; i < 300; i++) begin
            w = $urandom;
            check_word(w, req_of(w));
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule